// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes one 64-bit command word and turns it into a single 32-bit store into the register space of another core. The command carries the destination core number, an address field, a four-bit byte-keep mask and a 32-bit payload. When any keep bit is set, the block first fetches the destination word. It then writes back a word in which the kept bytes hold their old contents and every other byte takes the new payload. When no keep bit is set, the payload is stored directly and no fetch is made.

Two command offsets are decoded inside a 12-bit window. The mailbox command reaches one of eight mailbox words of the destination core. The free-address command reaches any 16-bit register offset. The destination core number is checked against the populated range. A number outside that range ends the command with a decode error and produces no downstream traffic. Downstream accesses use a valid/ready request channel and a response strobe. Each request carries the destination core number as its requester ID and enables all four little-endian byte lanes. The block handles one command at a time and raises `busy` from acceptance until its response.

Top module: `mbox_remote_writer`

## Requirements
- R1: A command is taken when `cmd_valid` is high and `busy` is low. It acts only when `cmd_is64` is 1 and `cmd_offset` equals `MAIL_OFS` or `ANY_OFS`. Any other command gives an OK response (`resp_err`=0) and makes no downstream access.
- R2: The destination core number is `cmd_data[25:16]`. A number below `ID_BASE` or at or above `ID_BASE+NUM_CORES` gives `resp_err`=1 and no downstream access. A valid number is driven on `dn_req_id` for every request of that command.
- R3: For the mailbox command, the address is `MBOX_BASE + 0x20 + (cmd_data & 0x1C)`. Bits 4:2 select one of eight words.
- R4: For the free-address command, the address is `cmd_data[15:0]`, zero-extended.
- R5: When `cmd_data[30:27]` is zero, exactly one write is issued, with data `cmd_data[63:32]`, and no read is made.
- R6: When `cmd_data[30:27]` is nonzero, one read of the destination address is followed by one write to it. In that write, byte i (bits 8i+7:8i) keeps the read value when bit 27+i is set and takes the payload byte otherwise.
- R7: A request holds its valid, direction, address and data unchanged until `dn_req_ready` is high. `dn_be` is always 4'b1111.
- R8: `busy` rises in the cycle after acceptance and stays high through the cycle in which `resp_valid` is high. Commands offered while busy are dropped.
- R9: Each accepted command gives exactly one single-cycle `resp_valid` pulse. `resp_err` is high only together with `resp_valid`.
- R10: After reset, `busy`, `resp_valid` and `dn_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_is64 | input | 1 | 1 when the access is a 64-bit write |
| cmd_offset | input | OFS_W | Offset of the command inside the decoded window |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Command in progress |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_err | output | 1 | Decode error, valid with resp_valid |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_addr | output | ADDR_W | Downstream register address |
| dn_req_id | output | 10 | Requester ID (destination core number) |
| dn_be | output | 4 | Byte lane enables |
| dn_wdata | output | 32 | Write data |
| dn_rsp_valid | input | 1 | Downstream completion strobe |
| dn_rdata | input | 32 | Read data, valid with dn_rsp_valid |

## Verification
On every cycle, the assertions check the request channel's hold rule and the range of the requester ID. They also check that a read is issued only when keep bits are set, that `resp_err` is tied to `resp_valid`, and that `busy` brackets the single response pulse. Only the bench scenarios can show that the merged data is correct byte by byte and that both address forms reach the right words. The same holds for unresolvable cores, wrong offsets and narrow accesses, which must leave the downstream untouched, and for commands dropped while busy.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned LANES     = WORD_W / 8;
   localparam int unsigned CORE_W    = 10;
   localparam int unsigned CMD_W     = 64;
   localparam int unsigned PAY_LSB   = 32;
   localparam int unsigned KEEP_LSB  = 27;
   localparam int unsigned CORE_LSB  = 16;
   localparam int unsigned MBOX_SKIP = 32'h20;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RD_WAIT,
      ST_WR,
      ST_WR_WAIT,
      ST_DONE
   } mbw_state_e;
endpackage

// File: rtl/mbw_decode.sv
module mbw_decode
   import mbw_pkg::*;
#(
   parameter int unsigned OFS_W     = 12,
   parameter int unsigned MAIL_OFS  = 12'h048,
   parameter int unsigned ANY_OFS   = 12'h158,
   parameter int unsigned ID_BASE   = 0,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MBOX_BASE = 16'h1000
) (
   input  logic [OFS_W-1:0]  ofs,
   input  logic              is64,
   input  logic [CMD_W-1:0]  cmd,
   output logic              hit,
   output logic              core_ok,
   output logic              need_rd,
   output logic [LANES-1:0]  keep,
   output logic [WORD_W-1:0] pay,
   output logic [CORE_W-1:0] core_id,
   output logic [ADDR_W-1:0] tgt_addr
);
   localparam logic [CORE_W:0]   ID_END   = CORE_W'(ID_BASE) + (CORE_W+1)'(NUM_CORES);
   localparam logic [ADDR_W-1:0] MBOX_W0  = ADDR_W'(MBOX_BASE + MBOX_SKIP);

   logic hit_mail, hit_any, lo_ok, hi_ok;
   logic [2:0] word_sel;
   logic unused_cmd;

   assign hit_mail = is64 && (ofs == OFS_W'(MAIL_OFS));
   assign hit_any  = is64 && (ofs == OFS_W'(ANY_OFS));
   assign hit      = hit_mail || hit_any;

   assign core_id  = cmd[CORE_LSB +: CORE_W];
   assign keep     = cmd[KEEP_LSB +: LANES];
   assign pay      = cmd[PAY_LSB +: WORD_W];
   assign need_rd  = |keep;
   assign word_sel = cmd[4:2];
   assign unused_cmd = ^{cmd[31], cmd[26]};

   generate
      if (ID_BASE == 0) begin : g_lo_free
         assign lo_ok = 1'b1;
      end else begin : g_lo_cmp
         assign lo_ok = core_id >= CORE_W'(ID_BASE);
      end
   endgenerate

   assign hi_ok   = {1'b0, core_id} < ID_END;
   assign core_ok = lo_ok && hi_ok;

   generate
      if (ADDR_W == 16) begin : g_addr_exact
         assign tgt_addr = hit_mail ? (MBOX_W0 + {11'd0, word_sel, 2'b00}) : cmd[15:0];
      end else begin : g_addr_wide
         assign tgt_addr = hit_mail ? (MBOX_W0 + {{(ADDR_W-5){1'b0}}, word_sel, 2'b00})
                                    : {{(ADDR_W-16){1'b0}}, cmd[15:0]};
      end
   endgenerate
endmodule

// File: rtl/mbw_merge.sv
module mbw_merge
   import mbw_pkg::*;
(
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] new_word,
   input  logic [LANES-1:0]  keep,
   output logic [WORD_W-1:0] merged
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = keep[i] ? old_word[8*i +: 8] : new_word[8*i +: 8];
   end
endmodule

// File: rtl/mbw_seq.sv
module mbw_seq
   import mbw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic act,
   input  logic bad_core,
   input  logic need_rd,
   input  logic req_ready,
   input  logic rsp_valid,
   output logic busy,
   output logic req_valid,
   output logic req_write,
   output logic capture,
   output logic resp_valid,
   output logic resp_err
);
   mbw_state_e st, st_nx;
   logic err_q;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    if (fire) st_nx = act ? (need_rd ? ST_RD : ST_WR) : ST_DONE;
         ST_RD:      if (req_ready) st_nx = ST_RD_WAIT;
         ST_RD_WAIT: if (rsp_valid) st_nx = ST_WR;
         ST_WR:      if (req_ready) st_nx = ST_WR_WAIT;
         ST_WR_WAIT: if (rsp_valid) st_nx = ST_DONE;
         ST_DONE:    st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         err_q <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == ST_IDLE && fire) err_q <= bad_core;
      end
   end

   assign busy       = (st != ST_IDLE);
   assign req_valid  = (st == ST_RD) || (st == ST_WR);
   assign req_write  = (st == ST_WR);
   assign capture    = (st == ST_RD_WAIT) && rsp_valid;
   assign resp_valid = (st == ST_DONE);
   assign resp_err   = (st == ST_DONE) && err_q;

   // R9
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !resp_valid) |=> busy);
   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fire) |=> busy);
endmodule

// File: rtl/mbox_remote_writer.sv
module mbox_remote_writer
   import mbw_pkg::*;
#(
   parameter int unsigned OFS_W     = 12,
   parameter int unsigned MAIL_OFS  = 12'h048,
   parameter int unsigned ANY_OFS   = 12'h158,
   parameter int unsigned ID_BASE   = 0,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MBOX_BASE = 16'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_is64,
   input  logic [OFS_W-1:0]  cmd_offset,
   input  logic [63:0]       cmd_data,
   output logic              busy,
   output logic              resp_valid,
   output logic              resp_err,
   output logic              dn_req_valid,
   input  logic              dn_req_ready,
   output logic              dn_req_write,
   output logic [ADDR_W-1:0] dn_req_addr,
   output logic [9:0]        dn_req_id,
   output logic [3:0]        dn_be,
   output logic [31:0]       dn_wdata,
   input  logic              dn_rsp_valid,
   input  logic [31:0]       dn_rdata
);
   localparam int unsigned ID_LIMIT = ID_BASE + NUM_CORES;

   generate
      if (NUM_CORES < 1 || ID_LIMIT > (1 << CORE_W)) begin : g_bad_cores
         $error("core range does not fit the 10-bit core field");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must hold a 16-bit register offset");
      end
      if (MAIL_OFS == ANY_OFS || MAIL_OFS >= (1 << OFS_W) || ANY_OFS >= (1 << OFS_W)) begin : g_bad_ofs
         $error("command offsets must differ and fit OFS_W");
      end
   endgenerate

   logic              hit, core_ok, need_rd, fire, capture;
   logic [LANES-1:0]  keep, keep_q;
   logic [WORD_W-1:0] pay, wdata_q, merged;
   logic [CORE_W-1:0] core_id, id_q;
   logic [ADDR_W-1:0] tgt_addr, addr_q;

   mbw_decode #(
      .OFS_W(OFS_W), .MAIL_OFS(MAIL_OFS), .ANY_OFS(ANY_OFS),
      .ID_BASE(ID_BASE), .NUM_CORES(NUM_CORES),
      .ADDR_W(ADDR_W), .MBOX_BASE(MBOX_BASE)
   ) i_decode (
      .ofs(cmd_offset), .is64(cmd_is64), .cmd(cmd_data),
      .hit(hit), .core_ok(core_ok), .need_rd(need_rd), .keep(keep),
      .pay(pay), .core_id(core_id), .tgt_addr(tgt_addr)
   );

   assign fire = cmd_valid && !busy;

   mbw_seq i_seq (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .act(hit && core_ok), .bad_core(hit && !core_ok), .need_rd(need_rd),
      .req_ready(dn_req_ready), .rsp_valid(dn_rsp_valid),
      .busy(busy), .req_valid(dn_req_valid), .req_write(dn_req_write),
      .capture(capture), .resp_valid(resp_valid), .resp_err(resp_err)
   );

   mbw_merge i_merge (
      .old_word(dn_rdata), .new_word(wdata_q), .keep(keep_q), .merged(merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         id_q    <= '0;
         keep_q  <= '0;
         wdata_q <= '0;
      end else if (fire) begin
         addr_q  <= tgt_addr;
         id_q    <= core_id;
         keep_q  <= keep;
         wdata_q <= pay;
      end else if (capture) begin
         wdata_q <= merged;
      end
   end

   assign dn_req_addr = addr_q;
   assign dn_req_id   = id_q;
   assign dn_wdata    = wdata_q;
   assign dn_be       = '1;

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_write)
         && $stable(dn_req_addr) && $stable(dn_wdata)));
   // R2
   id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid |-> ({1'b0, dn_req_id} >= (CORE_W+1)'(ID_BASE)
                        && {1'b0, dn_req_id} < (CORE_W+1)'(ID_LIMIT)));
   // R6
   read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req_valid && !dn_req_write) |-> (keep_q != '0));
   // R9
   err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> resp_valid);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dn_req_valid && !resp_valid));
endmodule

// File: tb/test_mbox_remote_writer.sv
`timescale 1ns/1ps
module test_mbox_remote_writer;
   localparam int unsigned MAIL = 12'h048;
   localparam int unsigned ANY  = 12'h158;
   localparam int unsigned BASE = 16'h1000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_is64 = 1'b0;
   logic [11:0] cmd_offset = '0;
   logic [63:0] cmd_data = '0;
   logic busy, resp_valid, resp_err, dn_req_valid, dn_req_write;
   logic [15:0] dn_req_addr;
   logic [9:0]  dn_req_id;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata, dn_rdata;
   logic dn_rsp_valid, stall = 1'b0;
   logic dn_req_ready;

   int n_cmp = 0, n_bad = 0, n_rd = 0, n_wr = 0;
   logic [9:0] last_id;
   logic [3:0] last_be;
   logic [31:0] mem [int unsigned];

   always #5 clk = ~clk;
   assign dn_req_ready = !stall;

   mbox_remote_writer #(.ID_BASE(2), .NUM_CORES(4)) i_mbox_remote_writer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is64(cmd_is64),
      .cmd_offset(cmd_offset), .cmd_data(cmd_data), .busy(busy),
      .resp_valid(resp_valid), .resp_err(resp_err), .dn_req_valid(dn_req_valid),
      .dn_req_ready(dn_req_ready), .dn_req_write(dn_req_write),
      .dn_req_addr(dn_req_addr), .dn_req_id(dn_req_id), .dn_be(dn_be),
      .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_rdata(dn_rdata)
   );

   // downstream register model: one-cycle response
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_rsp_valid <= 1'b0;
         dn_rdata     <= '0;
      end else begin
         dn_rsp_valid <= 1'b0;
         if (dn_req_valid && dn_req_ready) begin
            dn_rsp_valid <= 1'b1;
            last_id = dn_req_id;
            last_be = dn_be;
            if (dn_req_write) begin
               mem[dn_req_addr] = dn_wdata;
               n_wr++;
            end else begin
               dn_rdata <= mem.exists(dn_req_addr) ? mem[dn_req_addr] : 32'h0;
               n_rd++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [31:0] pay, input logic [3:0] keep,
                                      input logic [9:0] id, input logic [15:0] a);
      return {pay, 1'b0, keep, 1'b0, id, a};
   endfunction

   function automatic logic [31:0] blend(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] k);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = k[b] ? old[b*8 +: 8] : nw[b*8 +: 8];
      return r;
   endfunction

   task automatic issue(input logic [11:0] ofs, input bit w64, input logic [63:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_is64 = w64; cmd_offset = ofs; cmd_data = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic await(output bit err, output bit seen);
      seen = 1'b0; err = 1'b0;
      for (int i = 0; i < 60 && !seen; i++) begin
         if (resp_valid) begin seen = 1'b1; err = resp_err; end
         else @(negedge clk);
      end
      if (!seen) begin
         n_cmp++; n_bad++;
         $display("FAIL R9: actual no response expected response");
      end
      @(negedge clk);
   endtask

   task automatic clear_counts();
      n_rd = 0; n_wr = 0;
   endtask

   task automatic t_reset();
      chk(busy == 0, "R10 busy", busy, 0);
      chk(resp_valid == 0, "R10 resp_valid", resp_valid, 0);
      chk(dn_req_valid == 0, "R10 dn_req_valid", dn_req_valid, 0);
   endtask

   task automatic t_mail_plain();
      bit e, s;
      int unsigned a = BASE + 32'h20 + 32'hC;
      clear_counts();
      issue(MAIL, 1, mk(32'hCAFE_F00D, 4'b0000, 10'd3, 16'h00CF));
      await(e, s);
      chk(e == 0, "R3 err", e, 0);
      chk(n_rd == 0 && n_wr == 1, "R5 access count", {n_rd[31:0], n_wr[31:0]}, 64'h1);
      chk(mem.exists(a) && mem[a] == 32'hCAFE_F00D, "R3 mailbox word", mem.exists(a) ? mem[a] : 0, 32'hCAFE_F00D);
      chk(last_id == 10'd3, "R2 requester id", last_id, 3);
      chk(last_be == 4'hF, "R7 byte enables", last_be, 4'hF);
   endtask

   task automatic t_mail_masked();
      bit e, s;
      int unsigned a = BASE + 32'h20 + 32'h1C;
      mem[a] = 32'h1122_3344;
      clear_counts();
      issue(MAIL, 1, mk(32'hAABB_CCDD, 4'b0101, 10'd5, 16'hFFFF));
      await(e, s);
      chk(n_rd == 1 && n_wr == 1, "R6 read then write", {n_rd[31:0], n_wr[31:0]}, 64'h1_0000_0001);
      chk(mem[a] == blend(32'h1122_3344, 32'hAABB_CCDD, 4'b0101), "R6 merge 0101",
          mem[a], blend(32'h1122_3344, 32'hAABB_CCDD, 4'b0101));
      chk(last_id == 10'd5, "R2 top core id", last_id, 5);
   endtask

   task automatic t_any_keepall();
      bit e, s;
      mem[32'h0ABC] = 32'hDEAD_BEEF;
      clear_counts();
      issue(ANY, 1, mk(32'h0000_0000, 4'b1111, 10'd2, 16'h0ABC));
      await(e, s);
      chk(mem[32'h0ABC] == 32'hDEAD_BEEF, "R6 keep all", mem[32'h0ABC], 32'hDEAD_BEEF);
      chk(n_rd == 1 && n_wr == 1, "R4 one read one write", {n_rd[31:0], n_wr[31:0]}, 64'h1_0000_0001);
   endtask

   task automatic t_any_stall();
      bit e, s;
      logic [15:0] held;
      mem[32'hFFF4] = 32'h5566_7788;
      clear_counts();
      stall = 1'b1;
      issue(ANY, 1, mk(32'h99AA_BBCC, 4'b1000, 10'd4, 16'hFFF4));
      held = dn_req_addr;
      chk(dn_req_valid == 1 && dn_req_write == 0, "R7 read pending", dn_req_valid, 1);
      repeat (3) @(negedge clk);
      chk(dn_req_valid == 1 && dn_req_addr == held && held == 16'hFFF4, "R4 held address", dn_req_addr, 16'hFFF4);
      chk(busy == 1, "R8 busy while stalled", busy, 1);
      stall = 1'b0;
      await(e, s);
      chk(mem[32'hFFF4] == 32'h55AA_BBCC, "R6 merge 1000", mem[32'hFFF4], 32'h55AA_BBCC);
   endtask

   task automatic t_bad_core();
      bit e, s;
      clear_counts();
      issue(ANY, 1, mk(32'h1, 4'b0000, 10'd6, 16'h0100));
      await(e, s);
      chk(e == 1, "R2 err above range", e, 1);
      issue(MAIL, 1, mk(32'h1, 4'b0011, 10'd1, 16'h0000));
      await(e, s);
      chk(e == 1, "R2 err below range", e, 1);
      chk(n_rd == 0 && n_wr == 0, "R2 no access", {n_rd[31:0], n_wr[31:0]}, 0);
      chk(resp_err == 0, "R9 err cleared", resp_err, 0);
   endtask

   task automatic t_ignored();
      bit e, s;
      clear_counts();
      issue(12'h050, 1, mk(32'h7, 4'b0000, 10'd3, 16'h0200));
      await(e, s);
      chk(s && e == 0, "R1 wrong offset OK", e, 0);
      issue(ANY, 0, mk(32'h7, 4'b0000, 10'd3, 16'h0200));
      await(e, s);
      chk(s && e == 0, "R1 narrow access OK", e, 0);
      chk(n_rd == 0 && n_wr == 0 && !mem.exists(32'h0200), "R1 no access", {n_rd[31:0], n_wr[31:0]}, 0);
   endtask

   task automatic t_busy_drop();
      bit e, s;
      clear_counts();
      issue(ANY, 1, mk(32'h1234_5678, 4'b0000, 10'd3, 16'h0300));
      cmd_valid = 1'b1; cmd_is64 = 1'b1; cmd_offset = ANY; cmd_data = mk(32'h9, 4'b0000, 10'd3, 16'h0304);
      @(negedge clk);
      cmd_valid = 1'b0;
      await(e, s);
      repeat (4) @(negedge clk);
      chk(n_wr == 1 && !mem.exists(32'h0304), "R8 dropped while busy", n_wr, 1);
      chk(mem[32'h0300] == 32'h1234_5678, "R4 first command", mem[32'h0300], 32'h1234_5678);
      chk(busy == 0 && resp_valid == 0, "R9 single pulse", resp_valid, 0);
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mail_plain();
      t_mail_masked();
      t_any_keepall();
      t_any_stall();
      t_bad_core();
      t_ignored();
      t_busy_drop();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule